// File: doc/BRIEF.md
# Machine Clock Mode Switch Controller

This block decides which of three oscillators drives the machine clock: the main oscillator, the PLL, or the low-speed subclock. Software writes two source-select bits and a two-bit stabilization-wait code in a single write strobe. Two read-only flags report the source that is actually in use. When the requested source differs from the one in use, a timebase counter runs. The switch is committed only when the counter reaches the wait length that applies to that kind of transition.

The wait length depends on the transition. A main-to-PLL switch always waits a fixed PLL lock time. Switches that leave the subclock use the programmable code, and so does a wake from stop mode. A switch towards the subclock, or from the PLL back to the main clock, needs no oscillator start-up and commits at once. While a switch is pending, the select bits and the status flags disagree, and that mismatch is how the transition is reported. The one-hot source select drives an external glitch-free clock mux. It reads all zero while the block holds the machine clock for a stop-mode wake wait.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, clk_sel_o is 3'b001 (main), both flags and both select bits are 0, wait_sel_o is 2'b11 and busy_o is 0.
- R2: A write while idle loads the select bits and the wait code; the requested source is subclock when the subclock select is 1 (whatever the PLL select holds), else PLL when the PLL select is 1, else main; clk_sel_o bit 0 is main, bit 1 PLL, bit 2 subclock, and it is never more than one-hot.
- R3: A main-to-PLL switch commits exactly 2^PLL_LOG cycles after the write edge, regardless of the wait code.
- R4: A subclock-to-main switch commits after 2^TAPn_LOG cycles, where n is the wait code (00 to 11 giving TAP0 to TAP3).
- R5: A subclock-to-PLL switch uses the programmable tap but never less than 2^PLL_LOG cycles, so codes whose tap is shorter are raised to the PLL lock time.
- R6: Switches to the subclock, and PLL-to-main switches, commit one cycle after the write edge.
- R7: While a switch is pending, busy_o is 1 and the select bits differ from the flags (PLL select 1 with PLL flag 0 during the PLL wait; subclock select and flag disagree in either direction); when idle they agree.
- R8: A write while busy_o is 1, including in the cycle whose edge commits a switch, changes neither the select bits nor the wait code.
- R9: A wake pulse forces clk_sel_o to 3'b000 and busy_o to 1 from the next cycle, for 2^TAPn_LOG cycles of the current code (raised to 2^PLL_LOG when running on the PLL), after which the previous one-hot value returns.
- R10: The status flags and clk_sel_o change at the same clock edge, and only at the end of a pending switch.
- R11: A wake pulse sampled at the edge that would commit a switch wins: the switch is not committed, the wake wait runs first, and the switch then restarts its full wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base (oscillation) clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for select bits and wait code |
| wr_sub_sel_i | input | 1 | Subclock request bit to write |
| wr_pll_sel_i | input | 1 | PLL request bit to write |
| wr_wait_sel_i | input | 2 | Stabilization wait code to write |
| wake_i | input | 1 | Stop-mode wake event, one cycle |
| clk_sel_o | output | 3 | One-hot source select {sub, pll, main}; zero during a wake wait |
| sub_sel_o | output | 1 | Stored subclock request bit |
| pll_sel_o | output | 1 | Stored PLL request bit |
| wait_sel_o | output | 2 | Stored wait code |
| sub_flag_o | output | 1 | Subclock currently drives the machine clock |
| pll_flag_o | output | 1 | PLL currently drives the machine clock |
| busy_o | output | 1 | Switch or wake wait in progress |

## Verification
Two events can fall on the same clock edge: the commit of a pending switch can coincide with a new write, or with a wake pulse. The bench counts down to the last cycle of a main-to-PLL wait and drives each of these stimuli in exactly that cycle. For the write, it judges that the flags commit while the select bits and code keep their old values. For the wake, it judges that the commit is withheld, the clock select drops to zero for the wake wait, and the switch then takes its full fixed wait once more.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_SUB  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    WAIT_NONE    = 2'd0,
    WAIT_FIXED   = 2'd1,
    WAIT_TAP     = 2'd2,
    WAIT_TAP_PLL = 2'd3
  } wait_kind_e;

  function automatic src_e req_src(input logic sub_sel, input logic pll_sel);
    if (sub_sel)      return SRC_SUB;
    else if (pll_sel) return SRC_PLL;
    else              return SRC_MAIN;
  endfunction

  function automatic logic [2:0] src_onehot(input src_e src);
    case (src)
      SRC_PLL: return 3'b010;
      SRC_SUB: return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/mcs_wait_len.sv
module mcs_wait_len
  import mcs_pkg::*;
#(
  parameter int unsigned TAP0_LOG = 10,
  parameter int unsigned TAP1_LOG = 13,
  parameter int unsigned TAP2_LOG = 14,
  parameter int unsigned TAP3_LOG = 15,
  parameter int unsigned PLL_LOG  = 14,
  parameter int unsigned CNT_W    = 16
) (
  input  wait_kind_e       kind_i,
  input  logic [1:0]       code_i,
  output logic [CNT_W-1:0] last_o
);

  localparam int unsigned TAP_LOG [4] = '{TAP0_LOG, TAP1_LOG, TAP2_LOG, TAP3_LOG};
  localparam logic [CNT_W-1:0] PLL_LAST = CNT_W'((1 << PLL_LOG) - 1);

  logic [CNT_W-1:0] tap_last [4];

  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << TAP_LOG[g]) - 1);
    assign tap_last[g] = LAST;
  end

  logic [CNT_W-1:0] sel_tap;
  assign sel_tap = tap_last[code_i];

  always_comb begin
    case (kind_i)
      WAIT_FIXED:   last_o = PLL_LAST;
      WAIT_TAP:     last_o = sel_tap;
      WAIT_TAP_PLL: last_o = (sel_tap < PLL_LAST) ? PLL_LAST : sel_tap;
      default:      last_o = '0;
    endcase
  end

endmodule

// File: rtl/mcs_timebase.sv
module mcs_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  assign hit_o = run_i && !clr_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !run_i)    cnt_q <= '0;
    else if (hit_o)              cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import mcs_pkg::*;
#(
  parameter int unsigned TAP0_LOG = 10,
  parameter int unsigned TAP1_LOG = 13,
  parameter int unsigned TAP2_LOG = 14,
  parameter int unsigned TAP3_LOG = 15,
  parameter int unsigned PLL_LOG  = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sub_sel_i,
  input  logic       wr_pll_sel_i,
  input  logic [1:0] wr_wait_sel_i,
  input  logic       wake_i,
  output logic [2:0] clk_sel_o,
  output logic       sub_sel_o,
  output logic       pll_sel_o,
  output logic [1:0] wait_sel_o,
  output logic       sub_flag_o,
  output logic       pll_flag_o,
  output logic       busy_o
);

  localparam int unsigned MAX_A   = (TAP0_LOG > TAP1_LOG) ? TAP0_LOG : TAP1_LOG;
  localparam int unsigned MAX_B   = (TAP2_LOG > TAP3_LOG) ? TAP2_LOG : TAP3_LOG;
  localparam int unsigned MAX_T   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_LOG = (MAX_T > PLL_LOG) ? MAX_T : PLL_LOG;
  localparam int unsigned CNT_W   = MAX_LOG + 1;

  logic       sub_sel_q, pll_sel_q, wake_q;
  logic [1:0] wait_q;
  src_e       cur_q, tgt;
  wait_kind_e sw_kind, wk_kind, kind;
  logic       sw_pend, run, hit, wr_ok, wake_done, sw_done;
  logic [CNT_W-1:0] last;

  assign tgt     = req_src(sub_sel_q, pll_sel_q);
  assign sw_pend = (tgt != cur_q);
  assign busy_o  = sw_pend || wake_q;
  assign run     = busy_o;
  assign wr_ok   = wr_en_i && !busy_o;

  // wait kind is picked from the transition, not from the code alone
  always_comb begin
    if (cur_q == SRC_MAIN && tgt == SRC_PLL)      sw_kind = WAIT_FIXED;
    else if (cur_q == SRC_SUB && tgt == SRC_PLL)  sw_kind = WAIT_TAP_PLL;
    else if (cur_q == SRC_SUB && tgt == SRC_MAIN) sw_kind = WAIT_TAP;
    else                                          sw_kind = WAIT_NONE;
  end

  assign wk_kind = (cur_q == SRC_PLL) ? WAIT_TAP_PLL : WAIT_TAP;
  assign kind    = wake_q ? wk_kind : sw_kind;

  mcs_wait_len #(
    .TAP0_LOG(TAP0_LOG), .TAP1_LOG(TAP1_LOG), .TAP2_LOG(TAP2_LOG),
    .TAP3_LOG(TAP3_LOG), .PLL_LOG(PLL_LOG), .CNT_W(CNT_W)
  ) i_wait_len (
    .kind_i (kind),
    .code_i (wait_q),
    .last_o (last)
  );

  mcs_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wake_i),
    .run_i  (run),
    .last_i (last),
    .hit_o  (hit)
  );

  assign wake_done = wake_q && hit;
  assign sw_done   = !wake_q && sw_pend && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_sel_q <= 1'b0;
      pll_sel_q <= 1'b0;
      wait_q    <= 2'b11;
    end else if (wr_ok) begin
      sub_sel_q <= wr_sub_sel_i;
      pll_sel_q <= wr_pll_sel_i;
      wait_q    <= wr_wait_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wake_q <= 1'b0;
    else if (wake_i)    wake_q <= 1'b1;
    else if (wake_done) wake_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= SRC_MAIN;
    else if (sw_done) cur_q <= tgt;
  end

  assign clk_sel_o  = wake_q ? 3'b000 : src_onehot(cur_q);
  assign sub_sel_o  = sub_sel_q;
  assign pll_sel_o  = pll_sel_q;
  assign wait_sel_o = wait_q;
  assign sub_flag_o = (cur_q == SRC_SUB);
  assign pll_flag_o = (cur_q == SRC_PLL);

endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wake_i,
  input logic [2:0] clk_sel_o,
  input logic       sub_sel_o,
  input logic       pll_sel_o,
  input logic [1:0] wait_sel_o,
  input logic       sub_flag_o,
  input logic       pll_flag_o,
  input logic       busy_o
);

  AST_CLK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clk_sel_o)); // R2

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sub_flag_o && pll_flag_o)); // R2

  AST_IDLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sub_flag_o == sub_sel_o) && (pll_flag_o == (pll_sel_o && !sub_sel_o))); // R7

  AST_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i) |=> $stable({sub_sel_o, pll_sel_o, wait_sel_o})); // R8

  AST_WAKE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (clk_sel_o == 3'b000) && busy_o); // R9

  AST_FLAG_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({sub_flag_o, pll_flag_o}) |-> $past(busy_o) && (clk_sel_o != $past(clk_sel_o))); // R10

endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk i_clk_mode_ctrl_chk (.*);

// File: tb/test_clk_mode_ctrl.sv
module test_clk_mode_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sub = 1'b0, wr_pll = 1'b0, wake = 1'b0;
  logic [1:0] wr_wait = 2'b00;
  logic [2:0] clk_sel;
  logic       sub_sel, pll_sel, sub_flag, pll_flag, busy;
  logic [1:0] wait_sel;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // taps: 4, 8, 16, 32 cycles; PLL lock 16 cycles
  clk_mode_ctrl #(
    .TAP0_LOG(2), .TAP1_LOG(3), .TAP2_LOG(4), .TAP3_LOG(5), .PLL_LOG(4)
  ) i_clk_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sub_sel_i(wr_sub),
    .wr_pll_sel_i(wr_pll), .wr_wait_sel_i(wr_wait), .wake_i(wake),
    .clk_sel_o(clk_sel), .sub_sel_o(sub_sel), .pll_sel_o(pll_sel),
    .wait_sel_o(wait_sel), .sub_flag_o(sub_flag), .pll_flag_o(pll_flag),
    .busy_o(busy)
  );

  // {sub, pll, code[1:0], exp_sel[2:0], len[7:0]}
  localparam logic [14:0] VEC [16] = '{
    {1'b1, 1'b0, 2'b11, 3'b100, 8'd1},
    {1'b0, 1'b0, 2'b00, 3'b001, 8'd4},
    {1'b0, 1'b1, 2'b00, 3'b010, 8'd16},
    {1'b0, 1'b0, 2'b01, 3'b001, 8'd1},
    {1'b1, 1'b0, 2'b01, 3'b100, 8'd1},
    {1'b0, 1'b0, 2'b01, 3'b001, 8'd8},
    {1'b1, 1'b0, 2'b10, 3'b100, 8'd1},
    {1'b0, 1'b1, 2'b00, 3'b010, 8'd16},
    {1'b1, 1'b0, 2'b11, 3'b100, 8'd1},
    {1'b0, 1'b1, 2'b11, 3'b010, 8'd32},
    {1'b0, 1'b0, 2'b10, 3'b001, 8'd1},
    {1'b1, 1'b0, 2'b10, 3'b100, 8'd1},
    {1'b0, 1'b0, 2'b10, 3'b001, 8'd16},
    {1'b0, 1'b1, 2'b11, 3'b010, 8'd16},
    {1'b1, 1'b1, 2'b10, 3'b100, 8'd1},
    {1'b0, 1'b0, 2'b11, 3'b001, 8'd32}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge (index 0)
  task automatic do_write(input logic s, input logic p, input logic [1:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_sub = s; wr_pll = p; wr_wait = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic measure(input logic [2:0] exp_sel, inout int idx);
    while (clk_sel !== exp_sel && idx < 300) begin
      @(negedge clk);
      idx++;
    end
  endtask

  task automatic advance(inout int idx, input int to);
    while (idx < to) begin
      @(negedge clk);
      idx++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] prev;
    int idx;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 clk_sel", {29'd0, clk_sel}, 32'h1);
    check("R1 flags", {30'd0, sub_flag, pll_flag}, 32'h0);
    check("R1 sels", {30'd0, sub_sel, pll_sel}, 32'h0);
    check("R1 wait", {30'd0, wait_sel}, 32'h3);
    check("R1 busy", {31'd0, busy}, 32'h0);

    prev = 3'b001;
    for (int i = 0; i < 16; i++) begin
      logic [14:0] v;
      v = VEC[i];
      if (prev == 3'b001 && v[10:8] == 3'b010)      tag = "R3";
      else if (prev == 3'b100 && v[10:8] == 3'b001) tag = "R4";
      else if (prev == 3'b100 && v[10:8] == 3'b010) tag = "R5";
      else                                          tag = "R6";
      do_write(v[14], v[13], v[12:11]);
      idx = 0;
      check("R2 wait_sel", {30'd0, wait_sel}, {30'd0, v[12:11]});
      if (v[7:0] > 8'd1) begin
        check("R7 busy pending", {31'd0, busy}, 32'h1);
        check("R7 flags old", {30'd0, sub_flag, pll_flag}, {30'd0, prev[2], prev[1]});
        if (v[10:8] == 3'b010)
          check("R7 pll mismatch", {30'd0, pll_sel, pll_flag}, 32'h2);
        else
          check("R7 sub mismatch", {30'd0, sub_sel, sub_flag}, 32'h1);
      end
      measure(v[10:8], idx);
      check(tag, idx, {24'd0, v[7:0]});
      check("R10 flags with sel", {30'd0, sub_flag, pll_flag}, {30'd0, v[10], v[9]});
      check("R7 idle", {31'd0, busy}, 32'h0);
      prev = v[10:8];
    end

    // R8: write during pending switch is ignored
    do_write(1'b0, 1'b1, 2'b11);
    idx = 0;
    wr_en = 1'b1; wr_sub = 1'b1; wr_pll = 1'b0; wr_wait = 2'b00;
    @(negedge clk);
    idx = 1;
    wr_en = 1'b0;
    check("R8 sels kept", {30'd0, sub_sel, pll_sel}, 32'h1);
    check("R8 wait kept", {30'd0, wait_sel}, 32'h3);
    measure(3'b010, idx);
    check("R8 R3 length", idx, 32'd16);

    // R8: write in the commit cycle
    do_write(1'b0, 1'b0, 2'b11);
    idx = 0;
    measure(3'b001, idx);
    check("R6 pll to main", idx, 32'd1);
    do_write(1'b0, 1'b1, 2'b11);
    idx = 0;
    advance(idx, 15);
    check("R3 not yet", {29'd0, clk_sel}, 32'h1);
    wr_en = 1'b1; wr_sub = 1'b1; wr_pll = 1'b0; wr_wait = 2'b00;
    @(negedge clk);
    idx = 16;
    wr_en = 1'b0;
    check("R8 commit edge sel", {29'd0, clk_sel}, 32'h2);
    check("R8 commit edge sels", {30'd0, sub_sel, pll_sel}, 32'h1);
    check("R8 commit edge wait", {30'd0, wait_sel}, 32'h3);
    check("R8 commit edge busy", {31'd0, busy}, 32'h0);

    // R9: wake on PLL, code 00 raised to lock time
    do_write(1'b0, 1'b1, 2'b00);
    check("R2 code only", {31'd0, busy}, 32'h0);
    pulse_wake();
    idx = 0;
    check("R9 gated", {29'd0, clk_sel}, 32'h0);
    check("R9 busy", {31'd0, busy}, 32'h1);
    measure(3'b010, idx);
    check("R9 pll wake length", idx, 32'd16);

    // R9: wake on main, code 01
    do_write(1'b0, 1'b0, 2'b01);
    idx = 0;
    measure(3'b001, idx);
    check("R6 to main", idx, 32'd1);
    pulse_wake();
    idx = 0;
    check("R9 gated main", {29'd0, clk_sel}, 32'h0);
    measure(3'b001, idx);
    check("R9 main wake length", idx, 32'd8);

    // R11: wake at the commit edge of main-to-PLL
    do_write(1'b0, 1'b1, 2'b01);
    idx = 0;
    advance(idx, 15);
    wake = 1'b1;
    @(negedge clk);
    idx = 16;
    wake = 1'b0;
    check("R11 no commit", {30'd0, sub_flag, pll_flag}, 32'h0);
    check("R11 gated", {29'd0, clk_sel}, 32'h0);
    measure(3'b001, idx);
    check("R11 wake end", idx, 32'd24);
    check("R11 still pending", {30'd0, pll_sel, pll_flag}, 32'h2);
    measure(3'b010, idx);
    check("R11 full rewait", idx, 32'd40);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule